// File: doc/BRIEF.md
# Four-Operand Subtract-and-Branch Processor Core

This core runs programs built from a single instruction type. It keeps code and data in one word-addressed memory. Each instruction takes four consecutive words that hold four addresses: two source operands, a destination and a branch target. The core subtracts the second operand from the first, writes the difference to the destination word, and jumps to the target when that difference, read as a signed number, is zero or below. Otherwise it moves on to the instruction four words further along. The hardware has no immediates. Constants are ordinary memory words. Programs may rewrite their own instruction fields.

The core drives one synchronous single-port memory and makes at most one access per clock. A read issued in one cycle returns its data in the next cycle. Each instruction takes eight cycles: four field fetches, two operand reads, one write and one cycle that updates the program counter. A branch to the instruction's own address, or to the all-ones address, stops the core. It then raises a sticky halt flag and stops all memory traffic. A debug counter gives the number of cycles the core has run since reset.

Top module: `subbr_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, halt is 0, cycleCount is 0 and the memory port presents a read (memRe=1, memWe=0) of address 0.
- R2: Each instruction makes exactly this access sequence, one per cycle: reads of PC, PC+1, PC+2 and PC+3 (fields A, B, C, D in that order), a read of address A, a read of address B, a write to address C, then one cycle with no access.
- R3: The word written to address C equals mem[A] minus mem[B], modulo 2^W.
- R4: If the written word has its top bit set or is zero, the next instruction is fetched from address D. Otherwise it is fetched from PC+4.
- R5: Subtraction wraps without a trap. The branch decision uses the wrapped result even when the true difference overflows (for example 0x8000 minus 0x0001 gives 0x7FFF, which is positive, so the core falls through).
- R6: When C equals A or B, both operands are read before the write, so the old values are used.
- R7: A write to a word of a later instruction takes effect when that instruction is fetched.
- R8: A taken branch whose target equals the current PC sets halt. Halt then stays set until reset, and from then on memRe and memWe stay 0.
- R9: A taken branch to the all-ones address halts the core in the same way.
- R10: cycleCount increases by one on every clock edge on which the core is not halted, and holds its value once halt is set. A program of n instructions whose last instruction halts ends with cycleCount = 8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | W | Word address of the current memory access |
| memRe | output | 1 | Read strobe; data returns on memRdata one cycle later |
| memWe | output | 1 | Write strobe |
| memWdata | output | W | Data to write |
| memRdata | input | W | Read data from the previous cycle's read |
| halt | output | 1 | Sticky stop flag |
| cycleCount | output | CNT_W | Number of cycles run since reset |

## Verification
The hardest case to reach from the ports is self-modification. A write must land in a word the core has not yet fetched, and the core must then fetch the new value and not a stale one. The bench builds this from a first instruction whose destination is the branch-target word of the second instruction. It then checks that the core halts at the rewritten target and not at the one that was first loaded. The branch decision is swept over a grid of operand pairs that includes both signed overflow corners, and both the result word and the path taken are checked against arithmetic done in the bench.

// File: rtl/subbr_pkg.sv
package subbr_pkg;
  typedef enum logic [3:0] {
    S_FA, S_FB, S_FC, S_FD, S_RA, S_RB, S_WC, S_PC, S_HALT
  } state_t;

  typedef enum logic [2:0] {
    ADR_PC0, ADR_PC1, ADR_PC2, ADR_PC3, ADR_A, ADR_B, ADR_C
  } adr_sel_t;

  localparam int NUM_FIELDS = 4;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] ldField;
    logic                  ldOpA;
    logic                  ldRes;
    logic                  ldPc;
    logic                  cntEn;
    adr_sel_t              adrSel;
  } strobe_t;
endpackage

// File: rtl/subbr_ctrl.sv
module subbr_ctrl
  import subbr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    takeBranch,
  input  logic    stopTarget,
  output strobe_t strobe,
  output logic    memRe,
  output logic    memWe,
  output logic    halt
);
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FA;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    strobe        = '0;
    strobe.adrSel = ADR_PC0;
    strobe.cntEn  = (state != S_HALT);
    memRe         = 1'b0;
    memWe         = 1'b0;
    unique case (state)
      S_FA: begin memRe = 1'b1; strobe.adrSel = ADR_PC0; stateNext = S_FB; end
      S_FB: begin memRe = 1'b1; strobe.adrSel = ADR_PC1; strobe.ldField[0] = 1'b1; stateNext = S_FC; end
      S_FC: begin memRe = 1'b1; strobe.adrSel = ADR_PC2; strobe.ldField[1] = 1'b1; stateNext = S_FD; end
      S_FD: begin memRe = 1'b1; strobe.adrSel = ADR_PC3; strobe.ldField[2] = 1'b1; stateNext = S_RA; end
      S_RA: begin memRe = 1'b1; strobe.adrSel = ADR_A;   strobe.ldField[3] = 1'b1; stateNext = S_RB; end
      S_RB: begin memRe = 1'b1; strobe.adrSel = ADR_B;   strobe.ldOpA = 1'b1;      stateNext = S_WC; end
      S_WC: begin memWe = 1'b1; strobe.adrSel = ADR_C;   strobe.ldRes = 1'b1;      stateNext = S_PC; end
      S_PC: begin
        strobe.ldPc = 1'b1;
        stateNext   = (takeBranch && stopTarget) ? S_HALT : S_FA;
      end
      S_HALT: stateNext = S_HALT;
      default: stateNext = S_FA;
    endcase
  end

  assign halt = (state == S_HALT);
endmodule

// File: rtl/subbr_dp.sv
module subbr_dp
  import subbr_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  input  logic [W-1:0]     memRdata,
  output logic [W-1:0]     memAddr,
  output logic [W-1:0]     memWdata,
  output logic             takeBranch,
  output logic             stopTarget,
  output logic [CNT_W-1:0] cycleCount
);
  localparam logic [W-1:0] INSTR_WORDS = W'(NUM_FIELDS);
  localparam logic [W-1:0] HALT_ADDR   = '1;

  logic [W-1:0] pc, opA, res;
  logic [W-1:0] field [NUM_FIELDS];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)                    field[i] <= '0;
      else if (strobe.ldField[i]) field[i] <= memRdata;
    end
  end

  assign memWdata = opA - memRdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      opA        <= '0;
      res        <= '0;
      cycleCount <= '0;
    end else begin
      if (strobe.ldOpA) opA <= memRdata;
      if (strobe.ldRes) res <= memWdata;
      if (strobe.ldPc)  pc  <= takeBranch ? field[3] : pc + INSTR_WORDS;
      if (strobe.cntEn) cycleCount <= cycleCount + 1'b1;
    end
  end

  assign takeBranch = res[W-1] || (res == '0);
  assign stopTarget = (field[3] == pc) || (field[3] == HALT_ADDR);

  always_comb begin
    unique case (strobe.adrSel)
      ADR_PC0: memAddr = pc;
      ADR_PC1: memAddr = pc + W'(1);
      ADR_PC2: memAddr = pc + W'(2);
      ADR_PC3: memAddr = pc + W'(3);
      ADR_A:   memAddr = field[0];
      ADR_B:   memAddr = field[1];
      ADR_C:   memAddr = field[2];
      default: memAddr = pc;
    endcase
  end
endmodule

// File: rtl/subbr_core.sv
module subbr_core
  import subbr_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [W-1:0]     memAddr,
  output logic             memRe,
  output logic             memWe,
  output logic [W-1:0]     memWdata,
  input  logic [W-1:0]     memRdata,
  output logic             halt,
  output logic [CNT_W-1:0] cycleCount
);
  strobe_t strobe;
  logic    takeBranch, stopTarget;

  subbr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .takeBranch(takeBranch), .stopTarget(stopTarget),
    .strobe(strobe), .memRe(memRe), .memWe(memWe), .halt(halt)
  );

  subbr_dp #(.W(W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .takeBranch(takeBranch),
    .stopTarget(stopTarget), .cycleCount(cycleCount)
  );
endmodule

// File: rtl/subbr_core_chk.sv
module subbr_core_chk #(
  parameter int W     = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     memAddr,
  input logic             memRe,
  input logic             memWe,
  input logic             halt,
  input logic [CNT_W-1:0] cycleCount
);
  // R8: once set, halt stays set until reset
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst) halt |=> halt);
  // R8: a halted core makes no memory access
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst) halt |-> (!memRe && !memWe));
  // R10: the counter holds while halted
  a_r10_count_hold: assert property (@(posedge clk) disable iff (rst) halt |=> $stable(cycleCount));
  // R10: the counter steps by one while running
  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    !halt |=> (cycleCount == $past(cycleCount) + 1'b1));
  // R2: a write is followed by one cycle with no access
  a_r2_idle_after_write: assert property (@(posedge clk) disable iff (rst)
    memWe |=> (!memRe && !memWe));
  // R2: a write always comes right after a read
  a_r2_write_after_read: assert property (@(posedge clk) disable iff (rst)
    memWe |-> $past(memRe));
  // R2: never a read and a write in the same cycle
  a_r2_single_access: assert property (@(posedge clk) disable iff (rst) !(memRe && memWe));
  // R1: the address is known whenever the port is active
  a_r1_addr_known: assert property (@(posedge clk) disable iff (rst)
    (memRe || memWe) |-> !$isunknown(memAddr));
endmodule

bind subbr_core subbr_core_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
  .halt(halt), .cycleCount(cycleCount)
);

// File: tb/subbr_core_test.sv
module subbr_core_test;
  localparam int W     = 16;
  localparam int CNT_W = 32;
  localparam logic [15:0] MARK = 16'h5555;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [W-1:0]     memAddr, memWdata;
  logic [W-1:0]     memRdata = '0;
  logic             memRe, memWe, halt;
  logic [CNT_W-1:0] cycleCount;
  logic [W-1:0]     mem [256];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  subbr_core #(.W(W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .halt(halt), .cycleCount(cycleCount)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[7:0]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic putInstr(input int at, input logic [15:0] a, b, c, d);
    mem[at] = a; mem[at+1] = b; mem[at+2] = c; mem[at+3] = d;
  endtask

  task automatic startCore();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  // waits for halt; an expired limit is the watchdog and counts as a failure
  task automatic waitHalt(input string req);
    int n = 0;
    while (!halt && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!halt) begin
      checks++; errors++;
      $display("FAIL %s: watchdog expired, actual halt 0 expected 1", req);
    end
  endtask

  // two halting stubs: fall-through lands at 4 (clears 105), branch lands at 8 (clears 106)
  task automatic loadStubs();
    putInstr(4, 16'd103, 16'd103, 16'd105, 16'd4);
    putInstr(8, 16'd103, 16'd103, 16'd106, 16'd8);
    mem[105] = MARK; mem[106] = MARK;
  endtask

  initial begin
    logic [15:0] vals [8];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'hFFFF; vals[6] = 16'h1234; vals[7] = 16'hFFFE;

    // R1: reset state
    clearMem();
    putInstr(0, 16'd100, 16'd101, 16'd102, 16'd8);
    loadStubs();
    mem[100] = 16'd9; mem[101] = 16'd4;
    repeat (3) @(negedge clk);
    check("R1 halt in reset", halt, 0);
    check("R1 count in reset", cycleCount, 0);
    check("R1 read in reset", {memRe, memWe}, 2'b10);
    check("R1 addr in reset", memAddr, 0);

    // R2: access trace of one instruction, sampled mid-cycle
    @(negedge clk) rst = 1'b0;
    begin
      logic [15:0] expAddr [8];
      logic [1:0]  expRw [8];
      expAddr[0] = 0; expAddr[1] = 1; expAddr[2] = 2; expAddr[3] = 3;
      expAddr[4] = 100; expAddr[5] = 101; expAddr[6] = 102; expAddr[7] = 0;
      for (int k = 0; k < 8; k++) expRw[k] = (k < 6) ? 2'b10 : (k == 6 ? 2'b01 : 2'b00);
      for (int k = 0; k < 8; k++) begin
        if (k == 0) check("R1 first count", cycleCount, 0);
        check("R2 access kind", {memRe, memWe}, expRw[k]);
        if (k < 7) check("R2 access addr", memAddr, expAddr[k]);
        if (k == 6) check("R3 write data", memWdata, 16'd5);
        @(negedge clk);
      end
    end
    waitHalt("R2");
    check("R4 positive falls through", {mem[105], mem[106]}, {16'h0, MARK});
    check("R10 two instructions", cycleCount, 16);

    // R3 R4 R5: sweep over operand pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] a, b, diff;
        logic br, ovf;
        a = vals[i]; b = vals[j];
        diff = a - b;
        br = diff[15] || (diff == 0);
        ovf = (a[15] != b[15]) && (diff[15] != a[15]);
        clearMem();
        putInstr(0, 16'd100, 16'd101, 16'd102, 16'd8);
        loadStubs();
        mem[100] = a; mem[101] = b; mem[102] = MARK;
        startCore();
        waitHalt("R4");
        check("R3 difference", mem[102], diff);
        if (ovf) check("R5 wrapped branch", {mem[105], mem[106]}, br ? {MARK, 16'h0} : {16'h0, MARK});
        else     check("R4 branch choice", {mem[105], mem[106]}, br ? {MARK, 16'h0} : {16'h0, MARK});
        check("R10 count", cycleCount, 16);
      end
    end

    // R6: destination equals A
    clearMem();
    putInstr(0, 16'd100, 16'd101, 16'd100, 16'd8);
    loadStubs();
    mem[100] = 16'd7; mem[101] = 16'd3;
    startCore(); waitHalt("R6");
    check("R6 C==A result", mem[100], 16'd4);
    check("R6 C==A path", {mem[105], mem[106]}, {16'h0, MARK});

    // R6: destination equals B
    clearMem();
    putInstr(0, 16'd100, 16'd101, 16'd101, 16'd8);
    loadStubs();
    mem[100] = 16'd3; mem[101] = 16'd7;
    startCore(); waitHalt("R6");
    check("R6 C==B result", mem[101], 16'hFFFC);
    check("R6 C==B path", {mem[105], mem[106]}, {MARK, 16'h0});

    // R7: first instruction rewrites the branch target of the second
    clearMem();
    putInstr(0, 16'd110, 16'd111, 16'd7, 16'd32);
    putInstr(4, 16'd103, 16'd103, 16'd104, 16'd12);
    putInstr(12, 16'd103, 16'd103, 16'd106, 16'd12);
    putInstr(40, 16'd103, 16'd103, 16'd107, 16'd40);
    mem[110] = 16'd40; mem[106] = MARK; mem[107] = MARK;
    startCore(); waitHalt("R7");
    check("R7 rewritten field", mem[7], 16'd40);
    check("R7 new target used", {mem[106], mem[107]}, {MARK, 16'h0});
    check("R10 three instructions", cycleCount, 24);

    // R9: branch to all-ones address halts
    clearMem();
    putInstr(0, 16'd103, 16'd103, 16'd104, 16'hFFFF);
    mem[104] = MARK;
    startCore(); waitHalt("R9");
    check("R9 halted", halt, 1);
    check("R9 result written", mem[104], 0);
    check("R10 one instruction", cycleCount, 8);

    // R8: halt sticky, port quiet, counter frozen
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R8 halt sticky", halt, 1);
      check("R8 port quiet", {memRe, memWe}, 2'b00);
      check("R10 count held", cycleCount, 8);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule